// File: doc/BRIEF.md
# Complex Product Accumulator with Sliced Output Selection

This block multiplies a complex data sample by a unit (cos, sin) vector supplied by a neighbouring oscillator. It can sum the products in an accumulate-and-dump filter, and it presents 20-bit real and imaginary words taken from fixed bit windows of its result registers. A registered active-low enable gates a 19-bit complex input register. A two-term complex multiply fills a 35-bit product register every clock. A per-channel accumulator either adds the new product or is reloaded with it, under a registered accumulate/dump control. When it reloads, a holding register captures the sum that was built up. A 2-bit select chooses which slice of the product register or the accumulator holding register reaches each output.

The selected word can be rounded half-up to a width between 9 and 20 bits. Its most significant bit can be inverted to give offset binary for a converter. Four active-low enables, one each for the upper 4 and lower 16 bits of the real and imaginary outputs, are brought out as active-high drive flags for the pad ring.

Top module: `cmac_outmux_top`

## Requirements
- R1: The complex input register is loaded from `din_re`/`din_im` on a clock edge only when `din_en_n`, sampled on the previous edge, was low. Otherwise it keeps its contents. With the enable sampled high, changes on the data inputs never reach the outputs.
- R2: The product register holds real = xr·c − xi·s and imaginary = xr·s + xi·c. Here x is the input register and c, s are the signed 16-bit `cos_in`/`sin_in`. Both parts are 35-bit two's complement and wrap modulo 2^35.
- R3: When `acc_mode`, registered one clock earlier, is low (dump), the accumulator loads the current product. On the same edge the holding register captures the accumulator's previous value.
- R4: When registered `acc_mode` is high (accumulate), the accumulator adds the product to itself every clock, wrapping modulo 2^35, and the holding register keeps its value.
- R5: With `out_sel` = 00, output bits 19..16 are product bits 34..31 and output bits 15..0 are product bits 30..15.
- R6: With `out_sel` = 01, output bits 19..16 are product bits 34..31 and output bits 15..0 are product bits 14..0 followed by a 0 in bit 0.
- R7: With `out_sel` = 10, the output is accumulator holding register bits 19..0. With `out_sel` = 11, the selected word is all zeros.
- R8: When `fmt_twos`, registered one clock earlier, is low, bit 19 of both outputs is inverted after selection and rounding. When it is high, the words stay two's complement.
- R9: With `rnd_en_n` low, the selected word is rounded half-up to W bits. W is `rnd_width` clamped to the range 9..20. The rounding adds 2^(19−W) modulo 2^20 and clears the low 20−W bits. W = 20, or `rnd_en_n` high, leaves the word unchanged.
- R10: `drv_re` and `drv_im` are {upper, lower} drive flags. Each flag is high exactly when its active-low enable (`oe_*_hi_n`, `oe_*_lo_n`) is low.
- R11: Synchronous reset clears the input, product, accumulator and holding registers. It sets the registered input enable inactive, the accumulate control to dump and the format control to two's complement, so both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| din_en_n | input | 1 | Input register enable, active low, registered |
| din_re | input | 19 | Real part of the complex input, signed |
| din_im | input | 19 | Imaginary part of the complex input, signed |
| cos_in | input | 16 | Cosine term, signed |
| sin_in | input | 16 | Sine term, signed |
| acc_mode | input | 1 | 1 = accumulate, 0 = dump, registered |
| out_sel | input | 2 | Output slice select |
| fmt_twos | input | 1 | 1 = two's complement, 0 = offset binary, registered |
| rnd_en_n | input | 1 | Rounding enable, active low |
| rnd_width | input | 5 | Rounded width in bits (clamped to 9..20) |
| oe_re_hi_n | input | 1 | Real upper-field enable, active low |
| oe_re_lo_n | input | 1 | Real lower-field enable, active low |
| oe_im_hi_n | input | 1 | Imaginary upper-field enable, active low |
| oe_im_lo_n | input | 1 | Imaginary lower-field enable, active low |
| dout_re | output | 20 | Real output word |
| dout_im | output | 20 | Imaginary output word |
| drv_re | output | 2 | Real drive flags {upper, lower} |
| drv_im | output | 2 | Imaginary drive flags {upper, lower} |

## Verification
The in-line properties watch the register behaviour on every cycle. They check that the input register stays put while its registered enable is high. They check that a dump reloads the accumulator with the product and moves the old sum into the holding register, and that accumulate mode adds and leaves the holding register untouched. They also check that the reserved select yields zero. Only the bench scenarios can show that the multiply yields the right complex value for chosen operands, including the wrap at the most negative inputs. The same applies to the bit windows of each select code, the rounding at clamped widths, the offset-binary flip and the sum built over several accumulate cycles.

// File: rtl/cmac_pkg.sv
package cmac_pkg;
    localparam int DIN_W  = 19;
    localparam int CS_W   = 16;
    localparam int PROD_W = 35;
    localparam int OUT_W  = 20;
    localparam int HI_W   = 4;
    localparam int RW_W   = 5;
    localparam int MIN_RW = 9;

    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic [OUT_W-1:0]         oword_t;

    typedef struct packed {
        prod_t re;
        prod_t im;
    } cprod_t;

    typedef enum logic [1:0] {
        SEL_PROD_HI = 2'b00,
        SEL_PROD_LO = 2'b01,
        SEL_ACC     = 2'b10,
        SEL_NONE    = 2'b11
    } osel_e;

    function automatic oword_t pick_slice(osel_e sel, prod_t p, prod_t h);
        oword_t w;
        case (sel)
            SEL_PROD_HI: w = {p[34:31], p[30:15]};
            SEL_PROD_LO: w = {p[34:31], p[14:0], 1'b0};
            SEL_ACC:     w = h[OUT_W-1:0];
            default:     w = '0;
        endcase
        return w;
    endfunction

    function automatic oword_t round_to(oword_t w, logic [RW_W-1:0] width);
        int keep;
        int drop;
        oword_t half;
        oword_t mask;
        keep = int'(width);
        if (keep < MIN_RW) keep = MIN_RW;
        if (keep > OUT_W)  keep = OUT_W;
        drop = OUT_W - keep;
        if (drop == 0) return w;
        half = oword_t'(1) << (drop - 1);
        mask = ~((oword_t'(1) << drop) - oword_t'(1));
        return (w + half) & mask;
    endfunction
endpackage

// File: rtl/cmac_mult.sv
module cmac_mult
    import cmac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   din_en_n,
    input  logic signed [DIN_W-1:0] din_re,
    input  logic signed [DIN_W-1:0] din_im,
    input  logic signed [CS_W-1:0]  cos_in,
    input  logic signed [CS_W-1:0]  sin_in,
    output cprod_t                 prod
);
    logic                    en_q_n;
    logic signed [DIN_W-1:0] x_re;
    logic signed [DIN_W-1:0] x_im;
    prod_t                   rr, ii, ri, ir;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q_n <= 1'b1;
            x_re   <= '0;
            x_im   <= '0;
        end else begin
            en_q_n <= din_en_n;
            if (!en_q_n) begin
                x_re <= din_re;
                x_im <= din_im;
            end
        end
    end

    always_comb begin
        rr = prod_t'(x_re) * prod_t'(cos_in);
        ii = prod_t'(x_im) * prod_t'(sin_in);
        ri = prod_t'(x_re) * prod_t'(sin_in);
        ir = prod_t'(x_im) * prod_t'(cos_in);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prod <= '0;
        end else begin
            prod.re <= rr - ii;
            prod.im <= ri + ir;
        end
    end

    // R1: input register frozen while the registered enable is inactive
    p_input_hold_r1: assert property (@(posedge clk) disable iff (rst)
        en_q_n |=> ($stable(x_re) && $stable(x_im)));
endmodule

// File: rtl/cmac_accum.sv
module cmac_accum
    import cmac_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  acc_q,
    input  prod_t prod,
    output prod_t hold
);
    prod_t acc;
    prod_t feedback;

    assign feedback = acc_q ? acc : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            hold <= '0;
        end else begin
            acc <= feedback + prod;
            if (!acc_q) hold <= acc;
        end
    end

    // R3: dump reloads the accumulator with the product
    p_dump_load_r3: assert property (@(posedge clk) disable iff (rst)
        !acc_q |=> (acc == $past(prod)));
    // R3: dump moves the previous sum into the holding register
    p_dump_capture_r3: assert property (@(posedge clk) disable iff (rst)
        !acc_q |=> (hold == $past(acc)));
    // R4: accumulate adds and leaves the holding register alone
    p_accum_add_r4: assert property (@(posedge clk) disable iff (rst)
        acc_q |=> (acc == prod_t'($past(acc) + $past(prod))));
    p_accum_hold_r4: assert property (@(posedge clk) disable iff (rst)
        acc_q |=> $stable(hold));
endmodule

// File: rtl/cmac_outsel.sv
module cmac_outsel
    import cmac_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  osel_e           sel,
    input  prod_t           prod,
    input  prod_t           hold,
    input  logic            fmt_q,
    input  logic            rnd_en_n,
    input  logic [RW_W-1:0] rnd_width,
    input  logic            oe_hi_n,
    input  logic            oe_lo_n,
    output oword_t          dout,
    output logic [1:0]      drv
);
    oword_t picked;
    oword_t rounded;

    always_comb begin
        picked  = pick_slice(sel, prod, hold);
        rounded = rnd_en_n ? picked : round_to(picked, rnd_width);
        dout    = {rounded[OUT_W-1] ^ ~fmt_q, rounded[OUT_W-2:0]};
        drv     = {~oe_hi_n, ~oe_lo_n};
    end

    // R7: reserved select gives a zero word in two's complement
    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (sel == SEL_NONE && fmt_q) |-> (dout == '0));
endmodule

// File: rtl/cmac_outmux_top.sv
module cmac_outmux_top
    import cmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        din_en_n,
    input  logic [18:0] din_re,
    input  logic [18:0] din_im,
    input  logic [15:0] cos_in,
    input  logic [15:0] sin_in,
    input  logic        acc_mode,
    input  logic [1:0]  out_sel,
    input  logic        fmt_twos,
    input  logic        rnd_en_n,
    input  logic [4:0]  rnd_width,
    input  logic        oe_re_hi_n,
    input  logic        oe_re_lo_n,
    input  logic        oe_im_hi_n,
    input  logic        oe_im_lo_n,
    output logic [19:0] dout_re,
    output logic [19:0] dout_im,
    output logic [1:0]  drv_re,
    output logic [1:0]  drv_im
);
    localparam int NCH = 2;

    logic   acc_q;
    logic   fmt_q;
    cprod_t prod;
    prod_t  ch_prod [NCH];
    prod_t  ch_hold [NCH];
    oword_t ch_out  [NCH];
    logic [1:0] ch_drv [NCH];
    logic   ch_oe_hi_n [NCH];
    logic   ch_oe_lo_n [NCH];

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= 1'b0;
            fmt_q <= 1'b1;
        end else begin
            acc_q <= acc_mode;
            fmt_q <= fmt_twos;
        end
    end

    cmac_mult u_mult (
        .clk      (clk),
        .rst      (rst),
        .din_en_n (din_en_n),
        .din_re   (din_re),
        .din_im   (din_im),
        .cos_in   (cos_in),
        .sin_in   (sin_in),
        .prod     (prod)
    );

    assign ch_prod[0]    = prod.re;
    assign ch_prod[1]    = prod.im;
    assign ch_oe_hi_n[0] = oe_re_hi_n;
    assign ch_oe_lo_n[0] = oe_re_lo_n;
    assign ch_oe_hi_n[1] = oe_im_hi_n;
    assign ch_oe_lo_n[1] = oe_im_lo_n;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        cmac_accum u_acc (
            .clk   (clk),
            .rst   (rst),
            .acc_q (acc_q),
            .prod  (ch_prod[ch]),
            .hold  (ch_hold[ch])
        );
        cmac_outsel u_out (
            .clk       (clk),
            .rst       (rst),
            .sel       (osel_e'(out_sel)),
            .prod      (ch_prod[ch]),
            .hold      (ch_hold[ch]),
            .fmt_q     (fmt_q),
            .rnd_en_n  (rnd_en_n),
            .rnd_width (rnd_width),
            .oe_hi_n   (ch_oe_hi_n[ch]),
            .oe_lo_n   (ch_oe_lo_n[ch]),
            .dout      (ch_out[ch]),
            .drv       (ch_drv[ch])
        );
    end

    assign dout_re = ch_out[0];
    assign dout_im = ch_out[1];
    assign drv_re  = ch_drv[0];
    assign drv_im  = ch_drv[1];
endmodule

// File: tb/cmac_outmux_top_test.sv
module cmac_outmux_top_test;
    localparam int CLK_P = 10;
    localparam int NV = 6;
    localparam int TV_XR [NV] = '{1000, -262144, 262143, -7, 12345, 0};
    localparam int TV_XI [NV] = '{0, -262144, -5, 3, -23456, 100000};
    localparam int TV_C  [NV] = '{16384, -32768, 32767, 1, -1000, 0};
    localparam int TV_S  [NV] = '{0, -32768, -32768, 2, 30000, 32767};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic din_en_n = 1'b1;
    logic [18:0] din_re = '0, din_im = '0;
    logic [15:0] cos_in = '0, sin_in = '0;
    logic acc_mode = 1'b0;
    logic [1:0] out_sel = 2'b00;
    logic fmt_twos = 1'b1;
    logic rnd_en_n = 1'b1;
    logic [4:0] rnd_width = 5'd20;
    logic oe_re_hi_n = 1'b1, oe_re_lo_n = 1'b1, oe_im_hi_n = 1'b1, oe_im_lo_n = 1'b1;
    logic [19:0] dout_re, dout_im;
    logic [1:0] drv_re, drv_im;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    cmac_outmux_top uut (.*);

    task automatic chk(string req, logic [19:0] act, logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [34:0] mul_re(int xr, int xi, int c, int s);
        longint v;
        v = longint'(xr) * c - longint'(xi) * s;
        return v[34:0];
    endfunction

    function automatic logic [34:0] mul_im(int xr, int xi, int c, int s);
        longint v;
        v = longint'(xr) * s + longint'(xi) * c;
        return v[34:0];
    endfunction

    function automatic logic [19:0] want_slice(logic [1:0] sel, logic [34:0] p, logic [34:0] h);
        if (sel == 2'b00) return {p[34:31], p[30:15]};
        if (sel == 2'b01) return {p[34:31], p[14:0], 1'b0};
        if (sel == 2'b10) return h[19:0];
        return 20'h0;
    endfunction

    function automatic logic [19:0] want_round(logic [19:0] w, int width);
        int k;
        int d;
        k = (width < 9) ? 9 : ((width > 20) ? 20 : width);
        d = 20 - k;
        if (d == 0) return w;
        return (w + (20'd1 << (d - 1))) & ~((20'd1 << d) - 20'd1);
    endfunction

    task automatic load_vec(int xr, int xi, int c, int s);
        din_re = 19'(xr);
        din_im = 19'(xi);
        cos_in = 16'(c);
        sin_in = 16'(s);
        din_en_n = 1'b0;
        acc_mode = 1'b0;
        tick(6);
    endtask

    initial begin
        #(CLK_P * 50000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [34:0] pr, pi;
        tick(3);
        // R11: reset state
        chk("R11 reset re", dout_re, 20'h0);
        chk("R11 reset im", dout_im, 20'h0);
        out_sel = 2'b10;
        #1;
        chk("R11 reset hold re", dout_re, 20'h0);
        rst = 1'b0;
        tick(1);

        // R2 R5 R6 R7: table of vectors
        for (int v = 0; v < NV; v++) begin
            load_vec(TV_XR[v], TV_XI[v], TV_C[v], TV_S[v]);
            pr = mul_re(TV_XR[v], TV_XI[v], TV_C[v], TV_S[v]);
            pi = mul_im(TV_XR[v], TV_XI[v], TV_C[v], TV_S[v]);
            for (int s = 0; s < 3; s++) begin
                out_sel = 2'(s);
                #1;
                chk($sformatf("R2/R5/R6/R7 vec%0d sel%0d re", v, s), dout_re, want_slice(2'(s), pr, pr));
                chk($sformatf("R2/R5/R6/R7 vec%0d sel%0d im", v, s), dout_im, want_slice(2'(s), pi, pi));
            end
        end

        // R7: reserved select
        out_sel = 2'b11;
        #1;
        chk("R7 reserved re", dout_re, 20'h0);
        chk("R7 reserved im", dout_im, 20'h0);

        // R8: offset binary
        pr = mul_re(TV_XR[5], TV_XI[5], TV_C[5], TV_S[5]);
        pi = mul_im(TV_XR[5], TV_XI[5], TV_C[5], TV_S[5]);
        out_sel = 2'b00;
        fmt_twos = 1'b0;
        tick(1);
        chk("R8 offset bin re", dout_re, want_slice(2'b00, pr, pr) ^ 20'h80000);
        chk("R8 offset bin im", dout_im, want_slice(2'b00, pi, pi) ^ 20'h80000);
        fmt_twos = 1'b1;
        tick(1);

        // R9: rounding at several widths
        load_vec(1000, 0, 16384, 0);
        pr = mul_re(1000, 0, 16384, 0);
        out_sel = 2'b00;
        rnd_en_n = 1'b0;
        rnd_width = 5'd12;
        #1;
        chk("R9 round w12", dout_re, want_round(want_slice(2'b00, pr, pr), 12));
        rnd_width = 5'd3;
        #1;
        chk("R9 round clamp low", dout_re, want_round(want_slice(2'b00, pr, pr), 9));
        rnd_width = 5'd20;
        #1;
        chk("R9 round w20", dout_re, want_slice(2'b00, pr, pr));
        rnd_width = 5'd10;
        rnd_en_n = 1'b1;
        #1;
        chk("R9 round off", dout_re, want_slice(2'b00, pr, pr));

        // R3 R4: accumulate then dump
        load_vec(7, -3, 100, 50);
        pr = mul_re(7, -3, 100, 50);
        pi = mul_im(7, -3, 100, 50);
        out_sel = 2'b10;
        acc_mode = 1'b1;
        tick(4);
        chk("R4 hold kept re", dout_re, pr[19:0]);
        acc_mode = 1'b0;
        tick(2);
        chk("R3 dump sum re", dout_re, 20'(pr * 5));
        chk("R3 dump sum im", dout_im, 20'(pi * 5));
        tick(1);
        chk("R3 reload re", dout_re, pr[19:0]);

        // R1: disabled input register ignores data
        din_en_n = 1'b1;
        tick(2);
        din_re = 19'd555;
        din_im = 19'd444;
        tick(6);
        chk("R1 ignore re", dout_re, pr[19:0]);
        chk("R1 ignore im", dout_im, pi[19:0]);
        load_vec(555, 444, 100, 50);
        chk("R1 reload re", dout_re, 20'(mul_re(555, 444, 100, 50)));

        // R10: drive flags
        oe_re_hi_n = 1'b0;
        #1;
        chk("R10 drv re hi", {18'h0, drv_re}, 20'h2);
        chk("R10 drv im off", {18'h0, drv_im}, 20'h0);
        oe_re_lo_n = 1'b0;
        oe_im_hi_n = 1'b0;
        oe_im_lo_n = 1'b0;
        #1;
        chk("R10 drv re all", {18'h0, drv_re}, 20'h3);
        chk("R10 drv im all", {18'h0, drv_im}, 20'h3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule